// File: doc/BRIEF.md
# Addressed serial frame receiver

This block listens on an asynchronous serial line on which a host talks to many nodes. Every word on the line is eleven bits long. A node is addressed in two steps. First the host sends an address word that carries a 7-bit node number. Then it sends a command word that carries seven general-purpose command bits. The block compares each address word with its own strapped node address. When the address matches, it raises a one-clock pulse and holds a valid-address flag. A local transmitter can use that flag to decide when to answer. When the command word that follows arrives cleanly, the block latches its seven bits onto a parallel bus and raises a one-clock command strobe.

The system clock serves as the oscillator. One bit lasts a fixed number of clock cycles, 64 by default. Timing restarts at each start bit, so the host and the node only need clocks that agree closely over one word. Any word that fails its parity or stop-bit check is dropped. A command that does not directly follow a matching address is also dropped.

Top module: `addr_frame_rx`

## Requirements
- R1: A falling edge on the line begins a word only if the line is still low half a bit period later. One bit period is DIV clock cycles. A low glitch shorter than that produces no pulse and leaves the flag and the command bus as they were.
- R2: Each word is sent in this order. First a low start bit. Then seven payload bits, least significant first. Then a type bit. Then a parity bit that makes the eight data bits plus the parity bit hold an even number of ones. Last, a high stop bit. Each bit is sampled at the centre of its period.
- R3: An address word (type bit 1) whose payload equals the node address input, with correct parity and stop bit, produces exactly one vapPulse of one clock and sets addrValid.
- R4: Any other address word produces no vapPulse and clears addrValid. This covers a payload that differs from the node address, bad parity, or a low stop bit.
- R5: A command word (type bit 0) that arrives while addrValid is set, with correct parity and stop bit, puts its payload on cmdOut and produces exactly one cmdStrobe of one clock.
- R6: A command word that arrives while addrValid is clear, or that has bad parity or a low stop bit, produces no cmdStrobe and leaves cmdOut unchanged.
- R7: addrValid is clear after any command word ends, whether the command was accepted or rejected.
- R8: A stop bit sampled low makes the word invalid. The receiver does not look for a new start bit until the line has gone high again.
- R9: While rstN is low, cmdOut is 0, addrValid is 0 and neither pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; DIV cycles per bit |
| rstN | input | 1 | Asynchronous active-low reset |
| rxIn | input | 1 | Serial receive line, idle high |
| nodeAddr | input | ADDR_W | This node's address |
| vapPulse | output | 1 | One-clock pulse on a matching address word |
| cmdOut | output | ADDR_W | Latched command bits of the last accepted command |
| cmdStrobe | output | 1 | One-clock pulse when cmdOut is loaded |
| addrValid | output | 1 | Set by a matching address, cleared by the next command word |

## Verification
The bench sends commands without a preceding address, commands that come after an address meant for another node, and words with flipped parity. A design that skipped any of these checks would raise a strobe or overwrite the command bus. It also sends two commands after a single address; a design that failed to drop the flag would accept the second one. Address and command values of all zeros and all ones check the bit order, the parity sense and the type-bit position. A stop bit held low checks that the receiver waits for a high line before it looks for a new start; without that wait it would frame a phantom word. A short low glitch checks the mid-bit start confirmation.

// File: rtl/afr_pkg.sv
package afr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_BITS,
    ST_REARM
  } afr_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftEn;  // centre of a data or parity bit
    logic finish;   // centre of the stop bit
  } afr_ctl_t;
endpackage

// File: rtl/afr_sync.sv
module afr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= '1;
        else       pipe <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= '1;
        else       pipe <= {pipe[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/afr_ctrl.sv
module afr_ctrl
  import afr_pkg::*;
#(
  parameter int DIV     = 64,
  parameter int SAMPLES = 10
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     rxBit,
  output afr_ctl_t ctl
);
  localparam int CNT_W = $clog2(DIV);
  localparam int IDX_W = $clog2(SAMPLES + 1);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(DIV / 2 - 1);
  localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(DIV - 1);
  localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(SAMPLES - 1);

  afr_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic             sampleTick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      idx   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          idx <= '0;
          if (!rxBit) state <= ST_START;
        end
        ST_START: begin
          if (cnt == HALF_LAST) begin
            cnt   <= '0;
            state <= rxBit ? ST_IDLE : ST_BITS;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_BITS: begin
          if (cnt == BIT_LAST) begin
            cnt <= '0;
            idx <= idx + 1'b1;
            if (idx == IDX_LAST) state <= ST_REARM;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (rxBit) state <= ST_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    sampleTick  = (state == ST_BITS) && (cnt == BIT_LAST);
    ctl.shiftEn = sampleTick && (idx != IDX_LAST);
    ctl.finish  = sampleTick && (idx == IDX_LAST);
  end
endmodule

// File: rtl/afr_datapath.sv
module afr_datapath
  import afr_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxBit,
  input  afr_ctl_t          ctl,
  input  logic [ADDR_W-1:0] nodeAddr,
  output logic              vapPulse,
  output logic [ADDR_W-1:0] cmdOut,
  output logic              cmdStrobe,
  output logic              addrValid
);
  localparam int SR_W = ADDR_W + 2;  // payload, type bit, parity

  logic [SR_W-1:0] sr;
  logic isAddr, parityOk, frameOk, match, acceptCmd, acceptAddr;

  always_comb begin
    isAddr     = sr[ADDR_W];
    parityOk   = ~^sr;
    frameOk    = parityOk && rxBit;  // rxBit is the stop bit at finish
    match      = (sr[ADDR_W-1:0] == nodeAddr);
    acceptAddr = ctl.finish && isAddr && frameOk && match;
    acceptCmd  = ctl.finish && !isAddr && frameOk && addrValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sr        <= '0;
      vapPulse  <= 1'b0;
      cmdStrobe <= 1'b0;
      cmdOut    <= '0;
      addrValid <= 1'b0;
    end else begin
      if (ctl.shiftEn) sr <= {rxBit, sr[SR_W-1:1]};
      vapPulse  <= acceptAddr;
      cmdStrobe <= acceptCmd;
      if (acceptCmd)  cmdOut    <= sr[ADDR_W-1:0];
      if (ctl.finish) addrValid <= acceptAddr;
    end
  end
endmodule

// File: rtl/addr_frame_rx.sv
module addr_frame_rx
  import afr_pkg::*;
#(
  parameter int DIV         = 64,
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxIn,
  input  logic [ADDR_W-1:0] nodeAddr,
  output logic              vapPulse,
  output logic [ADDR_W-1:0] cmdOut,
  output logic              cmdStrobe,
  output logic              addrValid
);
  localparam int SAMPLES = ADDR_W + 3;  // payload, type, parity, stop

  logic     rxBit;
  afr_ctl_t ctl;

  afr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .din(rxIn), .dout(rxBit)
  );

  afr_ctrl #(.DIV(DIV), .SAMPLES(SAMPLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxBit(rxBit), .ctl(ctl)
  );

  afr_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .rxBit(rxBit), .ctl(ctl), .nodeAddr(nodeAddr),
    .vapPulse(vapPulse), .cmdOut(cmdOut), .cmdStrobe(cmdStrobe),
    .addrValid(addrValid)
  );
endmodule

// File: rtl/afr_checker.sv
module afr_checker #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              vapPulse,
  input logic [ADDR_W-1:0] cmdOut,
  input logic              cmdStrobe,
  input logic              addrValid
);
  a_r3_vap_single: assert property (@(posedge clk) disable iff (!rstN)
    vapPulse |=> !vapPulse);
  a_r3_vap_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    vapPulse |-> addrValid);
  a_r4_flag_rise_needs_vap: assert property (@(posedge clk) disable iff (!rstN)
    $rose(addrValid) |-> vapPulse);
  a_r5_strobe_single: assert property (@(posedge clk) disable iff (!rstN)
    cmdStrobe |=> !cmdStrobe);
  a_r5_strobe_after_flag: assert property (@(posedge clk) disable iff (!rstN)
    cmdStrobe |-> $past(addrValid));
  a_r6_cmd_hold: assert property (@(posedge clk) disable iff (!rstN)
    !cmdStrobe |-> $stable(cmdOut));
  a_r7_flag_dropped: assert property (@(posedge clk) disable iff (!rstN)
    cmdStrobe |-> !addrValid);
  a_r2_pulses_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(vapPulse && cmdStrobe));
endmodule

bind addr_frame_rx afr_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .vapPulse(vapPulse), .cmdOut(cmdOut),
  .cmdStrobe(cmdStrobe), .addrValid(addrValid)
);

// File: tb/sim_addr_frame_rx.sv
module sim_addr_frame_rx;
  localparam int DIV = 64;
  localparam int AW  = 7;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          rxIn = 1'b1;
  logic [AW-1:0] node = 7'h25;
  logic          vapPulse, cmdStrobe, addrValid;
  logic [AW-1:0] cmdOut;

  int vectors = 0, fails = 0;
  int vapCnt = 0, strCnt = 0;
  logic          mValid = 1'b0;
  logic [AW-1:0] mCmd = '0;

  always #4 clk = ~clk;

  addr_frame_rx #(.DIV(DIV), .ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .nodeAddr(node),
    .vapPulse(vapPulse), .cmdOut(cmdOut), .cmdStrobe(cmdStrobe),
    .addrValid(addrValid)
  );

  always @(negedge clk) begin
    if (rstN && vapPulse)  vapCnt++;
    if (rstN && cmdStrobe) strCnt++;
  end

  function automatic logic expectVap(input logic [AW-1:0] v, input logic flag,
                                     input logic ok, input logic [AW-1:0] n);
    return flag && ok && (v == n);
  endfunction

  function automatic logic expectStrobe(input logic flag, input logic ok,
                                        input logic valid);
    return !flag && ok && valid;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic sendWord(input logic [AW-1:0] v, input logic flag,
                          input logic badPar, input logic badStop);
    logic [AW:0] d;
    logic [AW+3:0] bits;
    d = {flag, v};
    bits = {~badStop, (^d) ^ badPar, d, 1'b0};
    for (int i = 0; i < AW + 4; i++) begin
      rxIn = bits[i];
      repeat (DIV) @(negedge clk);
    end
    rxIn = 1'b1;
    repeat (40) @(negedge clk);
  endtask

  task automatic doWord(input logic [AW-1:0] v, input logic flag,
                        input logic badPar, input logic badStop);
    int vb, sb;
    logic ok, eV, eS;
    string tag;
    vb = vapCnt; sb = strCnt;
    ok = !badPar && !badStop;
    eV = expectVap(v, flag, ok, node);
    eS = expectStrobe(flag, ok, mValid);
    sendWord(v, flag, badPar, badStop);
    if (flag) begin
      mValid = eV;
      tag = badStop ? "R8 addr" : (eV ? "R3 addr" : "R4 addr");
    end else begin
      if (eS) mCmd = v;
      mValid = 1'b0;
      tag = badStop ? "R8 cmd" : (eS ? "R5 cmd" : "R6 cmd");
    end
    chk({tag, " vap count"}, vapCnt - vb, int'(eV));
    chk({tag, " strobe count"}, strCnt - sb, int'(eS));
    chk({tag, " R2 cmdOut"}, int'(cmdOut), int'(mCmd));
    chk(flag ? {tag, " flag"} : {tag, " R7 flag"}, int'(addrValid), int'(mValid));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1469));
    repeat (5) @(negedge clk);
    // R9: reset state
    chk("R9 cmdOut in reset", int'(cmdOut), 0);
    chk("R9 flag in reset", int'(addrValid), 0);
    rstN = 1'b1;
    repeat (10) @(negedge clk);

    // directed: address then command
    doWord(7'h25, 1'b1, 1'b0, 1'b0);
    doWord(7'h5A, 1'b0, 1'b0, 1'b0);
    // second command without fresh address (R7/R6)
    doWord(7'h11, 1'b0, 1'b0, 1'b0);
    // address for another node (R4), then command
    doWord(7'h24, 1'b1, 1'b0, 1'b0);
    doWord(7'h33, 1'b0, 1'b0, 1'b0);
    // bad parity address, bad stop address (R4, R8)
    doWord(7'h25, 1'b1, 1'b1, 1'b0);
    doWord(7'h25, 1'b1, 1'b0, 1'b1);
    // good address, bad parity command, then bad stop command
    doWord(7'h25, 1'b1, 1'b0, 1'b0);
    doWord(7'h0F, 1'b0, 1'b1, 1'b0);
    doWord(7'h25, 1'b1, 1'b0, 1'b0);
    doWord(7'h0F, 1'b0, 1'b0, 1'b1);
    // extremes of node and payload values
    node = 7'h00;
    doWord(7'h00, 1'b1, 1'b0, 1'b0);
    doWord(7'h7F, 1'b0, 1'b0, 1'b0);
    node = 7'h7F;
    doWord(7'h7F, 1'b1, 1'b0, 1'b0);

    // R1: short glitch with flag set, then a command still accepted
    begin
      int vb, sb;
      vb = vapCnt; sb = strCnt;
      rxIn = 1'b0;
      repeat (DIV / 4) @(negedge clk);
      rxIn = 1'b1;
      repeat (2 * DIV) @(negedge clk);
      chk("R1 glitch vap", vapCnt - vb, 0);
      chk("R1 glitch strobe", strCnt - sb, 0);
      chk("R1 glitch flag", int'(addrValid), int'(mValid));
      chk("R1 glitch cmdOut", int'(cmdOut), int'(mCmd));
    end
    doWord(7'h00, 1'b0, 1'b0, 1'b0);

    // R9: reset in mid-run clears state
    doWord(7'h7F, 1'b1, 1'b0, 1'b0);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 flag after reset", int'(addrValid), 0);
    chk("R9 cmdOut after reset", int'(cmdOut), 0);
    rstN = 1'b1;
    mValid = 1'b0; mCmd = '0;
    repeat (10) @(negedge clk);

    // random transactions
    node = 7'h4C;
    for (int t = 0; t < 30; t++) begin
      logic [AW-1:0] a, c;
      a = ($urandom % 3 != 0) ? node : AW'($urandom);
      c = AW'($urandom);
      if ($urandom % 6 != 0)
        doWord(a, 1'b1, ($urandom % 8) == 0, ($urandom % 10) == 0);
      doWord(c, 1'b0, ($urandom % 8) == 0, ($urandom % 10) == 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule